// File: doc/BRIEF.md
# Bus Clock Rate and Multiplier Factor Control

This block holds the two control registers of a small system's clock unit and turns their contents into two outputs. The first register selects the rate of the bus-master clock. The rate is either the full system clock or the system clock divided by 2, 4, 8, 16 or 32. The block produces this rate as a single-cycle clock-enable strobe, `clk_en`. The second register holds a 2-bit frequency multiplication factor for an external PLL.

Two copies of the factor are kept. The written copy is what software reads back. The active copy drives `mult_act`. An update-mode bit in the first register decides when the active copy follows the written one. With the bit clear, it follows only when a standby-entry event arrives. With the bit set, it follows on the write itself.

Hardware standby clears the factor register and the active factor. Software standby keeps them. The system bus is a plain single-cycle register port with a 1-bit address.

Top module: `clkctl_top`

## Requirements
- R1: After reset both registers read 0x00, `mult_act` is 0, and `clk_en` is high on every cycle.
- R2: Address 0 holds the rate register: bits [2:0] are the rate select and bit 3 is the update-mode bit (1 = immediate). Address 1 holds the factor register with the factor in bits [1:0]. All other bits read as 0.
- R3: Rate select 000 gives `clk_en` high every cycle. Codes 001, 010, 011, 100 and 101 give a one-cycle pulse every 2, 4, 8, 16 and 32 cycles.
- R4: A write of rate code 110 or 111 is stored and read back, but the division in force stays as it was.
- R5: A new division starts at the next `clk_en` pulse. The gap that spans the write keeps the old length, and the gap after it has the new length.
- R6: With the update-mode bit at 0, a factor write leaves `mult_act` unchanged. A `stby_enter` pulse then loads the written factor into `mult_act` one cycle later.
- R7: With the update-mode bit at 1, a factor write sets `mult_act` on the cycle after the write.
- R8: While `hw_stby` is high, the factor register and `mult_act` are 0 and factor writes are dropped. The rate register is not affected.
- R9: A factor register read returns the written value, not the active one, and `stby_enter` leaves the register contents as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_stby | input | 1 | Hardware standby level |
| stby_enter | input | 1 | One-cycle software-standby entry event |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select (0 rate, 1 factor) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| clk_en | output | 1 | Bus-master clock enable strobe |
| mult_act | output | 2 | Active multiplication factor |

## Verification
The bench changes the division in the middle of a long period. A design that reloads its counter at once would produce a short first gap. It also writes reserved rate codes. A design that decodes the stored bits directly would stall the enable or pick a wrong period. Factor writes are mixed with standby events and with both update modes. A design that drives `mult_act` from the written copy, or that drops the pending value, shows a wrong active factor. Hardware standby is held high during a factor write, so a design that lets the write through, or that clears the rate register, is caught on read-back.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int REG_W     = 8;
  localparam int SEL_W     = 3;
  localparam int FAC_W     = 2;
  localparam int MODE_BIT  = 3;
  localparam int MAX_SHIFT = 5;

  localparam logic ADDR_RATE = 1'b0;
  localparam logic ADDR_FAC  = 1'b1;

  typedef enum logic [SEL_W-1:0] {
    SEL_FULL = 3'd0,
    SEL_D2   = 3'd1,
    SEL_D4   = 3'd2,
    SEL_D8   = 3'd3,
    SEL_D16  = 3'd4,
    SEL_D32  = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } rate_sel_e;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int RW    = REG_W,
  parameter int SW    = SEL_W,
  parameter int FW    = FAC_W,
  parameter int MB    = MODE_BIT,
  parameter int SMAX  = MAX_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  output logic [SW-1:0] sel_req,
  output logic          imm_mode,
  output logic [FW-1:0] fac_wr,
  output logic          fac_wr_fire,
  output logic [FW-1:0] fac_new
);
  logic [SW-1:0] sel_q, sel_d;
  logic [SW-1:0] req_q, req_d;
  logic          mode_q, mode_d;
  logic [FW-1:0] fac_q, fac_d;
  logic          rate_wr;
  logic          sel_ok;

  assign rate_wr     = wr_en && (addr == ADDR_RATE);
  assign fac_wr_fire = wr_en && (addr == ADDR_FAC) && !hw_stby;
  assign fac_new     = wdata[FW-1:0];
  assign sel_ok      = (wdata[SW-1:0] <= SW'(SMAX));

  always_comb begin
    sel_d  = sel_q;
    mode_d = mode_q;
    req_d  = req_q;
    if (rate_wr) begin
      sel_d  = wdata[SW-1:0];
      mode_d = wdata[MB];
      if (sel_ok) req_d = wdata[SW-1:0];
    end
  end

  always_comb begin
    fac_d = fac_q;
    if (hw_stby)          fac_d = '0;
    else if (fac_wr_fire) fac_d = fac_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= 1'b0;
      req_q  <= '0;
      fac_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
      req_q  <= req_d;
      fac_q  <= fac_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_RATE) begin
      rdata[SW-1:0] = sel_q;
      rdata[MB]     = mode_q;
    end else begin
      rdata[FW-1:0] = fac_q;
    end
  end

  assign sel_req  = req_q;
  assign imm_mode = mode_q;
  assign fac_wr   = fac_q;

  a_r4_reserved_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr && (wdata[SW-1:0] > SW'(SMAX))) |=> $stable(sel_req));
  a_r8_hw_clears_fac: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (fac_wr == '0));
  a_r8_hw_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby && !wr_en) |=> ($stable(sel_q) && $stable(imm_mode)));
endmodule

// File: rtl/clkctl_mult.sv
module clkctl_mult
  import clkctl_pkg::*;
#(
  parameter int FW = FAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          stby_enter,
  input  logic          imm_mode,
  input  logic          fac_wr_fire,
  input  logic [FW-1:0] fac_new,
  input  logic [FW-1:0] fac_wr,
  output logic [FW-1:0] fac_act
);
  logic [FW-1:0] act_q, act_d;
  logic          imm_load;

  assign imm_load = fac_wr_fire && imm_mode;

  always_comb begin
    act_d = act_q;
    if (hw_stby)         act_d = '0;
    else if (imm_load)   act_d = fac_new;
    else if (stby_enter) act_d = fac_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign fac_act = act_q;

  a_r7_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_load && !hw_stby) |=> (fac_act == $past(fac_new)));
  a_r6_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stby && !stby_enter && !imm_load) |=> $stable(fac_act));
  a_r6_standby_load: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_enter && !hw_stby && !imm_load) |=> (fac_act == $past(fac_wr)));
  a_r8_hw_clears_act: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (fac_act == '0));
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
  import clkctl_pkg::*;
#(
  parameter int SW   = SEL_W,
  parameter int SMAX = MAX_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel_req,
  output logic          clk_en
);
  localparam int CW = (SMAX > 0) ? SMAX : 1;

  logic [SW-1:0] div_q, div_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   span_req, span_cur;
  logic          term;

  assign span_req = ({{CW{1'b0}}, 1'b1} << sel_req) - 1'b1;
  assign span_cur = ({{CW{1'b0}}, 1'b1} << div_q) - 1'b1;
  assign term     = (cnt_q == '0);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q - 1'b1;
    if (term) begin
      div_d = sel_req;
      cnt_d = span_req[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign clk_en = term;

  a_r5_switch_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(div_q));
  a_r3_full_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> clk_en);
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} <= span_cur));
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int RW   = REG_W,
  parameter int SW   = SEL_W,
  parameter int FW   = FAC_W,
  parameter int MB   = MODE_BIT,
  parameter int SMAX = MAX_SHIFT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          stby_enter,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  output logic          clk_en,
  output logic [FW-1:0] mult_act
);
  logic          rst_meta, rst_sync;
  logic [SW-1:0] sel_req;
  logic          imm_mode;
  logic [FW-1:0] fac_wr;
  logic          fac_wr_fire;
  logic [FW-1:0] fac_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  clkctl_regs #(.RW(RW), .SW(SW), .FW(FW), .MB(MB), .SMAX(SMAX)) u_regs (
    .clk(clk), .rst_n(rst_sync), .hw_stby(hw_stby), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sel_req(sel_req),
    .imm_mode(imm_mode), .fac_wr(fac_wr), .fac_wr_fire(fac_wr_fire),
    .fac_new(fac_new)
  );

  clkctl_mult #(.FW(FW)) u_mult (
    .clk(clk), .rst_n(rst_sync), .hw_stby(hw_stby), .stby_enter(stby_enter),
    .imm_mode(imm_mode), .fac_wr_fire(fac_wr_fire), .fac_new(fac_new),
    .fac_wr(fac_wr), .fac_act(mult_act)
  );

  clkctl_div #(.SW(SW), .SMAX(SMAX)) u_div (
    .clk(clk), .rst_n(rst_sync), .sel_req(sel_req), .clk_en(clk_en)
  );
endmodule

// File: tb/sim_clkctl_top.sv
module sim_clkctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_stby = 1'b0;
  logic       stby_enter = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       clk_en;
  logic [1:0] mult_act;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [2:0] m_sel = 3'd0;
  logic       m_mode = 1'b0;
  logic [2:0] m_req = 3'd0;
  logic [1:0] m_fac = 2'd0;
  logic [1:0] m_act = 2'd0;

  clkctl_top u0 (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .stby_enter(stby_enter),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .clk_en(clk_en), .mult_act(mult_act)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_gap(logic [2:0] r);
    return 1 << r;
  endfunction

  function automatic logic [7:0] exp_rate_rd();
    return {4'b0000, m_mode, m_sel};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 1'b0) begin
      m_sel = d[2:0]; m_mode = d[3];
      if (d[2:0] <= 3'd5) m_req = d[2:0];
    end else if (!hw_stby) begin
      m_fac = d[1:0];
      if (m_mode) m_act = d[1:0];
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic stby_pulse();
    @(negedge clk);
    stby_enter = 1'b1;
    @(negedge clk);
    stby_enter = 1'b0;
    m_act = m_fac;
  endtask

  task automatic wait_pulse(output int t);
    t = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (clk_en) begin t = cyc; break; end
    end
  endtask

  task automatic check_regs(input string req);
    logic [7:0] v;
    rd(1'b0, v);
    check(v == exp_rate_rd(), req, v, exp_rate_rd());
    rd(1'b1, v);
    check(v == {6'b0, m_fac}, req, v, {6'b0, m_fac});
    check(mult_act == m_act, req, mult_act, m_act);
  endtask

  task automatic check_gap(input string req);
    int t0, t1;
    wait_pulse(t0);
    wait_pulse(t1);
    check((t1 - t0) == exp_gap(m_req), req, t1 - t0, exp_gap(m_req));
  endtask

  initial begin
    int unsigned seed;
    int t0, t1, t2;
    logic [7:0] v;
    seed = $urandom(32'd9173);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_regs("R1");
    check(clk_en == 1'b1, "R1", clk_en, 1);
    check_gap("R1");

    // R2 field positions, upper bits read zero
    wr(1'b0, 8'hF2);
    check_regs("R2");
    wr(1'b1, 8'hFD);
    check_regs("R2");

    // R3 every division
    for (int s = 0; s <= 5; s++) begin
      wr(1'b0, 8'(s));
      check_gap("R3");
      check_gap("R3");
    end

    // R4 reserved codes keep the previous division
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h06);
    check_regs("R4");
    check_gap("R4");
    wr(1'b0, 8'h07);
    check_regs("R4");
    check_gap("R4");

    // R5 change in mid period
    wr(1'b0, 8'h05);
    wait_pulse(t0);
    wait_pulse(t0);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h01);
    wait_pulse(t1);
    wait_pulse(t2);
    check((t1 - t0) == 32, "R5", t1 - t0, 32);
    check((t2 - t1) == 2, "R5", t2 - t1, 2);

    // R6 and R9 deferred update
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h03);
    check(mult_act == m_act, "R6", mult_act, m_act);
    rd(1'b1, v);
    check(v == 8'h03, "R9", v, 3);
    stby_pulse();
    check(mult_act == 2'd3, "R6", mult_act, 3);
    rd(1'b1, v);
    check(v == 8'h03, "R9", v, 3);

    // R7 immediate update
    wr(1'b0, 8'h08);
    wr(1'b1, 8'h01);
    check(mult_act == 2'd1, "R7", mult_act, 1);
    check_regs("R7");

    // R8 hardware standby with a write during it
    @(negedge clk);
    hw_stby = 1'b1; wr_en = 1'b1; addr = 1'b1; wdata = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    m_fac = 2'd0; m_act = 2'd0;
    check_regs("R8");
    @(negedge clk);
    hw_stby = 1'b0;
    check_regs("R8");

    // constrained random mix
    for (int it = 0; it < 200; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 3)      wr(1'b0, 8'($urandom % 16));
      else if (op < 7) wr(1'b1, 8'($urandom));
      else if (op < 9) stby_pulse();
      else begin
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk); hw_stby = 1'b0;
        m_fac = 2'd0; m_act = 2'd0;
      end
      check_regs("R9");
      if (it % 25 == 0) check_gap("R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule